// File: doc/BRIEF.md
# Cascadable Eight-Request Priority Encoder

This block turns a wide vector of request lines into the binary index of the most important one. Its building element is an eight-lane encoder. Requests, the enable and every output flag are active low. The highest-numbered lane that is asserted wins. Each element has an enable input, a "this group holds the winner" flag and a pass-along flag. The pass-along flag asserts only when the element is enabled and sees no request, so elements can be chained from most to least important.

The top level chains eight such elements over 64 request lines. The pass-along flag of each group drives the enable of the group just below it. Only the highest group that holds a request is therefore active. A ninth element takes the eight group flags as its requests, and its code gives the upper three index bits. The lower three bits merge the codes of all eight groups. An idle group presents all-inactive code lines, so only the single active group affects the merge. The block is purely combinational. Its outputs are an active-high index, an active-high valid flag and an active-low pass-along flag for chaining further cascades.

Top module: `prio_enc_cascade`

## Requirements
- R1: With the enable asserted (`en_n` = 0) and exactly one request line k driven low, `idx` equals k and `valid` is 1.
- R2: When several requests inside the same group of eight lanes are low, `idx` is the highest-numbered of them.
- R3: When requests are low in more than one group, `idx` is the highest-numbered request overall. A request in a higher group wins over any request in a lower group.
- R4: With the enable asserted and all 64 request lines high, `valid` is 0, `idx` is 0 and `pass_n` is 0.
- R5: With the enable deasserted (`en_n` = 1), `valid` is 0, `idx` is 0 and `pass_n` is 1, whatever the request lines carry.
- R6: With the enable asserted and at least one request low, `pass_n` is 1.
- R7: Inside the cascade, at most one group reports that it holds the winning request at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Cascade enable, active low |
| req_n | input | 64 | Request lines, active low; bit k is request k, and bit 63 has the highest priority |
| idx | output | 6 | Index of the winning request, active high; 0 when `valid` is 0 |
| valid | output | 1 | High when the cascade is enabled and some request is active |
| pass_n | output | 1 | Active low; asserted when the cascade is enabled and no request is active, for chaining a lower cascade |

## Verification
A wrong pass-along link or a wrong group flag shows up at once as a wrong upper index field. Because the block has no storage, the wrong value appears in the same cycle as the request pattern that exposes it. A faulty lane decode or merge corrupts the lower three index bits. This only shows for a request pattern whose winning lane exercises the bad term. That is why the bench mixes single, dense and cross-group patterns. An enable that does not gate every output shows up as a nonzero `valid` or a wrong `pass_n` on the first disabled pattern that carries requests.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;

    localparam int LANES  = 8;
    localparam int CODE_W = $clog2(LANES);

    typedef struct packed {
        logic [CODE_W-1:0] code_n;
        logic              grp_n;
        logic              pass_n;
    } enc_flags_t;

    // Highest set bit of an active-high vector; returns 0 when none is set.
    function automatic logic [CODE_W-1:0] top_lane(input logic [LANES-1:0] hits);
        logic [CODE_W-1:0] pos;
        pos = '0;
        for (int i = 0; i < LANES; i++) begin
            if (hits[i]) pos = CODE_W'(i);
        end
        return pos;
    endfunction

endpackage

// File: rtl/prio_enc_unit.sv
module prio_enc_unit
    import prio_enc_pkg::*;
(
    input  logic             en_n,
    input  logic [LANES-1:0] req_n,
    output enc_flags_t       flags
);

    logic [LANES-1:0] hits;
    logic             any_hit;
    logic             enabled;

    always_comb begin
        hits    = ~req_n;
        any_hit = |hits;
        enabled = ~en_n;

        flags.code_n = '1;
        flags.grp_n  = 1'b1;
        flags.pass_n = 1'b1;
        if (enabled) begin
            if (any_hit) begin
                flags.code_n = ~top_lane(hits);
                flags.grp_n  = 1'b0;
            end else begin
                flags.pass_n = 1'b0;
            end
        end
    end

    // An idle or disabled element keeps its code lines inactive (supports R4, R5)
    always_comb begin
        if (flags.grp_n) begin
            assert_idle_code_R4: assert (flags.code_n == '1)
                else $error("element drives a code while not holding a request");
        end
    end

    // Group flag and pass-along flag are never asserted together (R6)
    always_comb begin
        assert_flag_excl_R6: assert (flags.grp_n || flags.pass_n)
            else $error("group and pass flags both asserted");
    end

endmodule

// File: rtl/prio_code_merge.sv
module prio_code_merge
    import prio_enc_pkg::*;
#(
    parameter int GROUPS = 8
) (
    input  logic [GROUPS-1:0][CODE_W-1:0] codes_n,
    output logic [CODE_W-1:0]             merged_n
);

    always_comb begin
        merged_n = '1;
        for (int g = 0; g < GROUPS; g++) begin
            merged_n = merged_n & codes_n[g];
        end
    end

endmodule

// File: rtl/prio_enc_cascade.sv
module prio_enc_cascade
    import prio_enc_pkg::*;
#(
    parameter int GROUPS = 8,
    localparam int REQS  = GROUPS * LANES,
    localparam int IDX_W = $clog2(REQS)
) (
    input  logic             en_n,
    input  logic [REQS-1:0]  req_n,
    output logic [IDX_W-1:0] idx,
    output logic             valid,
    output logic             pass_n
);

    enc_flags_t                    grp_flags [GROUPS];
    logic [GROUPS:0]               chain_n;
    logic [GROUPS-1:0]             grp_hit_n;
    logic [GROUPS-1:0][CODE_W-1:0] grp_codes_n;
    logic [CODE_W-1:0]             low_code_n;
    logic [LANES-1:0]              sel_req_n;
    enc_flags_t                    sel_flags;

    // Chain runs from the highest group down: chain_n[GROUPS] is the external enable.
    assign chain_n[GROUPS] = en_n;

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        prio_enc_unit u_unit (
            .en_n  (chain_n[g+1]),
            .req_n (req_n[g*LANES +: LANES]),
            .flags (grp_flags[g])
        );
        assign chain_n[g]     = grp_flags[g].pass_n;
        assign grp_hit_n[g]   = grp_flags[g].grp_n;
        assign grp_codes_n[g] = grp_flags[g].code_n;
    end

    prio_code_merge #(.GROUPS(GROUPS)) u_merge (
        .codes_n  (grp_codes_n),
        .merged_n (low_code_n)
    );

    // Group selector: unused lanes (when GROUPS < LANES) are held inactive.
    for (genvar s = 0; s < LANES; s++) begin : g_sel
        if (s < GROUPS) begin : g_used
            assign sel_req_n[s] = grp_hit_n[s];
        end else begin : g_spare
            assign sel_req_n[s] = 1'b1;
        end
    end

    prio_enc_unit u_group_sel (
        .en_n  (1'b0),
        .req_n (sel_req_n),
        .flags (sel_flags)
    );

    assign valid  = ~sel_flags.grp_n;
    assign idx    = IDX_W'({~sel_flags.code_n, ~low_code_n});
    assign pass_n = chain_n[0];

    // Only one group may claim the winner (R7)
    always_comb begin
        assert_one_group_R7: assert ($onehot0(~grp_hit_n))
            else $error("more than one group active");
    end

    // With the cascade disabled no group may report a request (R5)
    always_comb begin
        if (en_n) begin
            assert_disabled_quiet_R5: assert (grp_hit_n == '1 && chain_n[0])
                else $error("disabled cascade shows activity");
        end
    end

    // Group selector agrees with the chained flags: some group active iff valid (R3)
    always_comb begin
        assert_sel_agree_R3: assert (valid == !(&grp_hit_n))
            else $error("group selector disagrees with group flags");
    end

endmodule

// File: tb/tb_prio_enc_cascade.sv
module tb_prio_enc_cascade;

    localparam int REQS  = 64;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en_n;
    logic [REQS-1:0]  req_n;
    logic [IDX_W-1:0] idx;
    logic             valid;
    logic             pass_n;

    always #10 clk = ~clk;

    prio_enc_cascade dut (
        .en_n   (en_n),
        .req_n  (req_n),
        .idx    (idx),
        .valid  (valid),
        .pass_n (pass_n)
    );

    typedef struct {
        logic [IDX_W-1:0] idx;
        logic             valid;
        logic             pass_n;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    bit   summary_shown = 0;

    function automatic exp_t model(input logic e_n, input logic [REQS-1:0] r_n, input string tag);
        exp_t x;
        x.tag = tag;
        x.idx = '0;
        x.valid = 1'b0;
        x.pass_n = 1'b1;
        if (!e_n) begin
            x.pass_n = 1'b0;
            for (int k = 0; k < REQS; k++) begin
                if (!r_n[k]) begin
                    x.idx = IDX_W'(k);
                    x.valid = 1'b1;
                    x.pass_n = 1'b1;
                end
            end
        end
        return x;
    endfunction

    task automatic drive(input logic e_n, input logic [REQS-1:0] r_n, input string tag);
        @(negedge clk);
        en_n  = e_n;
        req_n = r_n;
        exp_q.push_back(model(e_n, r_n, tag));
    endtask

    // Monitor: inputs change at negedge, outputs sampled at the following posedge.
    always @(posedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (idx !== e.idx || valid !== e.valid || pass_n !== e.pass_n) begin
                bad++;
                $display("FAIL %s: idx=%0d valid=%0b pass_n=%0b expected idx=%0d valid=%0b pass_n=%0b",
                         e.tag, idx, valid, pass_n, e.idx, e.valid, e.pass_n);
            end
        end
    end

    task automatic show_summary();
        if (!summary_shown) begin
            summary_shown = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    initial begin
        en_n  = 1'b1;
        req_n = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state: disabled, no requests (R5)
        drive(1'b1, '1, "R5 reset state");

        // R1: single request on every line
        for (int k = 0; k < REQS; k++) begin
            logic [REQS-1:0] r;
            r = '1;
            r[k] = 1'b0;
            drive(1'b0, r, "R1 single request");
        end

        // R4: enabled, idle
        drive(1'b0, '1, "R4 no requests");

        // R2: dense requests inside one group
        for (int g = 0; g < 8; g++) begin
            for (int n = 0; n < 6; n++) begin
                logic [REQS-1:0] r;
                logic [7:0] m;
                r = '1;
                m = 8'($urandom) | 8'(1 << n);
                r[g*8 +: 8] = ~m;
                drive(1'b0, r, "R2 same group");
            end
        end

        // R3: requests across groups, including the 7/8 boundary
        begin
            logic [REQS-1:0] r;
            r = '1; r[7] = 1'b0; r[8] = 1'b0;
            drive(1'b0, r, "R3 group boundary");
            r = '1; r[0] = 1'b0; r[63] = 1'b0;
            drive(1'b0, r, "R3 extremes");
        end
        for (int n = 0; n < 200; n++) begin
            logic [REQS-1:0] r;
            r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            drive(1'b0, ~r, "R3 R6 random multi-group");
        end

        // R5: disabled with requests present
        for (int n = 0; n < 20; n++) begin
            drive(1'b1, {$urandom, $urandom}, "R5 disabled");
        end
        drive(1'b1, '0, "R5 disabled all requests");

        // R6: enabled with all lines requesting
        drive(1'b0, '0, "R6 all requests");

        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        done = 1;
        show_summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            show_summary();
            $finish;
        end
    end

endmodule